// File: doc/BRIEF.md
# Network Adapter Probe Sequencer

This block runs once at start-up, before the host lets the network controller loose. It identifies the adapter and works out how the adapter's shared memory and interrupt line are set up. On `start` it first issues an ASIC reset pulse through the board control register and waits a settling interval. It then reads a board identifier out of an ID port. The identifier comes back as four nibbles, and each read carries its own position, so the reads may arrive in any order. The block fetches configuration words from an external EEPROM reader over a request/acknowledge port.

From one EEPROM byte the block derives the base and size of the shared-memory window. It checks that byte for legal encodings. It holds the network controller in reset while it adds up the whole EEPROM, and that sum must equal the board identifier. When the window is large enough, the block programs the memory-decode registers. It then translates the encoded interrupt line and writes that code back to the board with interrupts left disabled. When the sequence ends, a one-cycle `done` pulse reports pass or fail. The derived configuration stays on the outputs until the next `start`.

The register bus is a single-cycle strobe bus: a write completes in the cycle its strobe is high, and read data is returned in the same cycle as the read strobe.

Top module: `adapter_probe`

## Requirements
- R1: After reset the block is idle. `done`, `passed`, `present`, `memValid`, `regWr`, `regRd` and `eeReq` are all 0.
- R2: On `start` the block writes 0x40 to the control register (address 0x0E) and then 0x00 to it in the next cycle. The first ID-port read (address 0x0F) comes exactly WAIT_CYCLES+1 cycles after the zero write.
- R3: The block reads the ID port four times. Each read ORs bits 7:4 into the identifier at bit offset 4×(bits 1:0). Bits 3:2 are ignored. `present` is 1 when the result equals BOARD_ID.
- R4: If the identifier differs from BOARD_ID, the block ends with `passed`=0 and `present`=0. It makes no EEPROM request and no further register write.
- R5: The window byte is the low byte of EEPROM word CFG_WORD (6). Let pg be the index of its lowest set bit. The byte shifted right by pg must be 0x01, 0x03, 0x07 or 0x0F, giving 16, 32, 48 or 64 KB at base 0xC0000 + pg×0x4000.
- R6: A window byte of 0 is valid and means no shared memory: base 0 and size 0.
- R7: Any other window byte ends the probe with `passed`=0, `present`=1 and `memValid`=0. No write follows the two reset writes.
- R8: After a valid window byte, the block writes 0x80 to the control register. It then reads EEPROM words 0 to 63 in ascending order. Their 16-bit wrapping sum must equal BOARD_ID, otherwise the probe fails with no further write.
- R9: `pioMode` is 1 when the window size is 0 or 16 KB. In that case no memory-decode register is written.
- R10: For 32, 48 and 64 KB, decode = ((1<<size/16K)−1)<<pg. The block writes, in this order: decode[7:0] to 0x0A, 0x10|(pg[1:0]<<2) to 0x0B, ~decode[7:0] to 0x18, and {~decode[11:8],decode[11:8]} to 0x1A.
- R11: The 3-bit IRQ code in bits 15:13 of EEPROM word IRQ_WORD (1) maps 0→0, 1→9, 2→3, 3→4, 4→5, 5→10, 6→11, 7→0 on `irqNum`. The raw code is written to address 0x0D with the enable bit (bit 3) clear, as the last write of a passing probe.
- R12: `done` is high for exactly one cycle. `passed` is 1 in that cycle only if every step succeeded, and it holds until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (accepted when idle) |
| regWr | output | 1 | Register write strobe |
| regRd | output | 1 | Register read strobe |
| regAddr | output | 8 | Register address |
| regWdata | output | 8 | Register write data |
| regRdata | input | 8 | Register read data, valid with `regRd` |
| eeReq | output | 1 | EEPROM word request, held until acknowledged |
| eeAddr | output | 6 | EEPROM word address |
| eeAck | input | 1 | EEPROM word acknowledge |
| eeData | input | 16 | EEPROM word, valid with `eeAck` |
| done | output | 1 | One-cycle end-of-probe pulse |
| passed | output | 1 | Probe succeeded |
| present | output | 1 | Board identifier matched |
| memValid | output | 1 | Window byte decoded to a legal value |
| memBase | output | 20 | Shared-memory base address |
| memKb | output | 7 | Shared-memory size in KB |
| pioMode | output | 1 | Use programmed I/O instead of the window |
| irqNum | output | 4 | Translated interrupt line, 0 if none |
| decodeVal | output | 8 | Memory-decode byte |
| pageVal | output | 8 | Page-control byte |
| extVal | output | 8 | Extended-decode byte |

## Verification
The zero write lands in the cycle after the ASIC reset write, and the first ID read follows it by exactly WAIT_CYCLES+1 cycles. The bench stamps every bus write and the first read of each ID group with a free-running cycle count, so it checks that spacing exactly rather than merely its order. Each EEPROM word costs two cycles: the request, then the acknowledge cycle in which the block captures the word. Because of this, the decoded window is visible on the outputs one cycle after the word-6 acknowledge, and `irqNum` one cycle after the IRQ-word acknowledge. All results are therefore stable before `done`, which rises in the cycle after the final IRQ write or in the cycle after the failing check. The bench samples every result on the falling edge at which it first sees `done`. It then checks one falling edge later that `done` has dropped and `passed` is unchanged.

// File: rtl/probe_pkg.sv
package probe_pkg;

  // Register map used by the sequencer
  localparam logic [7:0] CTRL_REG  = 8'h0E;
  localparam logic [7:0] ID_REG    = 8'h0F;
  localparam logic [7:0] IRQ_REG   = 8'h0D;
  localparam logic [7:0] DEC_REG   = 8'h0A;
  localparam logic [7:0] WIN_REG   = 8'h0B;
  localparam logic [7:0] PAGE_REG  = 8'h18;
  localparam logic [7:0] EXT_REG   = 8'h1A;

  // Control register values
  localparam logic [7:0] ASIC_RST  = 8'h40;
  localparam logic [7:0] NET_RST   = 8'h80;
  localparam logic [7:0] WIDE_BUS  = 8'h10;
  localparam int         IRQ_EN_BIT = 3;

  localparam int EE_AW   = 6;
  localparam int EE_LAST = (1 << EE_AW) - 1;
  localparam int ID_READS = 4;

  typedef enum logic [2:0] {
    WS_ASIC, WS_ZERO, WS_NET, WS_DEC, WS_WIN, WS_PAGE, WS_EXT, WS_IRQ
  } wrSel_t;

  typedef struct packed {
    logic   clearAll;
    logic   idCapture;
    logic   idLatch;
    logic   cfgCapture;
    logic   sumAdd;
    logic   irqCapture;
    wrSel_t wrSel;
  } strobe_t;

endpackage

// File: rtl/probe_datapath.sv
module probe_datapath
  import probe_pkg::*;
#(
  parameter logic [15:0] BOARD_ID = 16'h5A3C,
  parameter int          IRQ_LSB  = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic        regRd,
  input  logic [7:0]  regRdata,
  input  logic [15:0] eeData,
  output logic [7:0]  regAddr,
  output logic [7:0]  regWdata,
  output logic        idMatch,
  output logic        memOk,
  output logic        pioSel,
  output logic        sumOk,
  output logic        present,
  output logic        memValid,
  output logic [19:0] memBase,
  output logic [6:0]  memKb,
  output logic        pioMode,
  output logic [3:0]  irqNum,
  output logic [7:0]  decodeVal,
  output logic [7:0]  pageVal,
  output logic [7:0]  extVal
);

  localparam int DEC_W = 12;
  localparam logic [19:0] WIN_ORIGIN = 20'hC0000;

  logic [15:0] idAccum;
  logic        idDone;
  logic [7:0]  cfgByte;
  logic        cfgDone;
  logic [15:0] sumAcc;
  logic [2:0]  irqCode;
  logic        irqDone;

  logic [2:0]       pg;
  logic             pgFound;
  logic [7:0]       rest;
  logic [2:0]       units;
  logic [DEC_W-1:0] mask;
  logic [DEC_W-1:0] decodeFull;
  logic [15:0]      idPiece;

  // Nibble placed at the position the read itself names
  assign idPiece = {12'h000, regRdata[7:4]} << {regRdata[1:0], 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearAll) begin
      idAccum <= '0;
      idDone  <= 1'b0;
      cfgByte <= '0;
      cfgDone <= 1'b0;
      sumAcc  <= '0;
      irqCode <= '0;
      irqDone <= 1'b0;
    end else begin
      if (stb.idCapture)  idAccum <= idAccum | idPiece;
      if (stb.idLatch)    idDone  <= 1'b1;
      if (stb.cfgCapture) begin
        cfgByte <= eeData[7:0];
        cfgDone <= 1'b1;
      end
      if (stb.sumAdd)     sumAcc  <= sumAcc + eeData;
      if (stb.irqCapture) begin
        irqCode <= eeData[IRQ_LSB +: 3];
        irqDone <= 1'b1;
      end
    end
  end

  // Lowest set bit of the window byte
  always_comb begin
    pg      = '0;
    pgFound = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!pgFound && cfgByte[i]) begin
        pg      = 3'(i);
        pgFound = 1'b1;
      end
    end
  end

  assign rest = cfgByte >> pg;

  always_comb begin
    memOk = 1'b1;
    case (rest)
      8'h00:   units = 3'd0;
      8'h01:   units = 3'd1;
      8'h03:   units = 3'd2;
      8'h07:   units = 3'd3;
      8'h0F:   units = 3'd4;
      default: begin
        units = 3'd0;
        memOk = 1'b0;
      end
    endcase
  end

  assign mask       = (DEC_W'(1) << units) - DEC_W'(1);
  assign decodeFull = mask << pg;
  assign pioSel     = (units <= 3'd1);

  function automatic logic [3:0] irqMap(input logic [2:0] code);
    case (code)
      3'd1:    irqMap = 4'd9;
      3'd2:    irqMap = 4'd3;
      3'd3:    irqMap = 4'd4;
      3'd4:    irqMap = 4'd5;
      3'd5:    irqMap = 4'd10;
      3'd6:    irqMap = 4'd11;
      default: irqMap = 4'd0;
    endcase
  endfunction

  assign idMatch  = (idAccum == BOARD_ID);
  assign sumOk    = (sumAcc == BOARD_ID);
  assign present  = idDone && idMatch;
  assign memValid = cfgDone && memOk;
  assign memBase  = (memValid && units != 3'd0) ? (WIN_ORIGIN + {3'b000, pg, 14'h0000}) : 20'h00000;
  assign memKb    = memValid ? {units, 4'b0000} : 7'd0;
  assign pioMode  = memValid && pioSel;
  assign irqNum   = irqDone ? irqMap(irqCode) : 4'd0;

  always_comb begin
    if (memValid && !pioSel) begin
      decodeVal = decodeFull[7:0];
      pageVal   = ~decodeFull[7:0];
      extVal    = {~decodeFull[11:8], decodeFull[11:8]};
    end else begin
      decodeVal = '0;
      pageVal   = '0;
      extVal    = '0;
    end
  end

  // Bus address and write data selected by the controller
  always_comb begin
    regAddr  = CTRL_REG;
    regWdata = '0;
    if (regRd) begin
      regAddr = ID_REG;
    end else begin
      case (stb.wrSel)
        WS_ASIC: begin regAddr = CTRL_REG; regWdata = ASIC_RST; end
        WS_ZERO: begin regAddr = CTRL_REG; regWdata = 8'h00;    end
        WS_NET:  begin regAddr = CTRL_REG; regWdata = NET_RST;  end
        WS_DEC:  begin regAddr = DEC_REG;  regWdata = decodeFull[7:0]; end
        WS_WIN:  begin regAddr = WIN_REG;  regWdata = WIDE_BUS | {4'h0, pg[1:0], 2'b00}; end
        WS_PAGE: begin regAddr = PAGE_REG; regWdata = ~decodeFull[7:0]; end
        WS_EXT:  begin regAddr = EXT_REG;  regWdata = {~decodeFull[11:8], decodeFull[11:8]}; end
        WS_IRQ:  begin regAddr = IRQ_REG;  regWdata = {5'b00000, irqCode}; end
        default: begin regAddr = CTRL_REG; regWdata = 8'h00; end
      endcase
    end
  end

  // R9
  pio_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    pioMode |-> (memKb <= 7'd16));

  // R5
  size_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memKb[3:0] == 4'd0 && memKb <= 7'd64));

endmodule

// File: rtl/probe_ctrl.sv
module probe_ctrl
  import probe_pkg::*;
#(
  parameter int WAIT_CYCLES = 12000,
  parameter int CFG_WORD    = 6,
  parameter int IRQ_WORD    = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             eeAck,
  input  logic             idMatch,
  input  logic             memOk,
  input  logic             pioSel,
  input  logic             sumOk,
  output strobe_t          stb,
  output logic             regWr,
  output logic             regRd,
  output logic             eeReq,
  output logic [EE_AW-1:0] eeAddr,
  output logic             done,
  output logic             passed
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 64);
  localparam logic [CNT_W-1:0] WAIT_END = CNT_W'(WAIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] ID_END   = CNT_W'(ID_READS - 1);
  localparam logic [CNT_W-1:0] EE_END   = CNT_W'(EE_LAST);
  localparam logic [CNT_W-1:0] DEC_END  = CNT_W'(3);

  typedef enum logic [3:0] {
    S_IDLE, S_ARST, S_ACLR, S_WAIT, S_ID, S_IDCHK, S_CFG, S_CFGCHK,
    S_NRST, S_SUM, S_SUMCHK, S_DEC, S_IRQRD, S_IRQWR, S_PASS, S_FAIL
  } state_t;

  state_t           state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             passReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      passReg <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      if (stb.clearAll)        passReg <= 1'b0;
      else if (state == S_IRQWR) passReg <= 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    stb       = '0;
    stb.wrSel = WS_ASIC;
    regWr     = 1'b0;
    regRd     = 1'b0;
    eeReq     = 1'b0;
    eeAddr    = '0;
    case (state)
      S_IDLE: if (start) begin
        stb.clearAll = 1'b1;
        stateNext    = S_ARST;
      end
      S_ARST: begin
        regWr     = 1'b1;
        stb.wrSel = WS_ASIC;
        stateNext = S_ACLR;
      end
      S_ACLR: begin
        regWr     = 1'b1;
        stb.wrSel = WS_ZERO;
        cntNext   = '0;
        stateNext = S_WAIT;
      end
      S_WAIT: begin
        if (cnt == WAIT_END) begin
          cntNext   = '0;
          stateNext = S_ID;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      S_ID: begin
        regRd         = 1'b1;
        stb.idCapture = 1'b1;
        if (cnt == ID_END) begin
          cntNext   = '0;
          stateNext = S_IDCHK;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      S_IDCHK: begin
        stb.idLatch = 1'b1;
        stateNext   = idMatch ? S_CFG : S_FAIL;
      end
      S_CFG: begin
        eeReq  = 1'b1;
        eeAddr = EE_AW'(CFG_WORD);
        if (eeAck) begin
          stb.cfgCapture = 1'b1;
          stateNext      = S_CFGCHK;
        end
      end
      S_CFGCHK: stateNext = memOk ? S_NRST : S_FAIL;
      S_NRST: begin
        regWr     = 1'b1;
        stb.wrSel = WS_NET;
        cntNext   = '0;
        stateNext = S_SUM;
      end
      S_SUM: begin
        eeReq  = 1'b1;
        eeAddr = cnt[EE_AW-1:0];
        if (eeAck) begin
          stb.sumAdd = 1'b1;
          if (cnt == EE_END) begin
            cntNext   = '0;
            stateNext = S_SUMCHK;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
      end
      S_SUMCHK: begin
        cntNext = '0;
        if (!sumOk)      stateNext = S_FAIL;
        else if (pioSel) stateNext = S_IRQRD;
        else             stateNext = S_DEC;
      end
      S_DEC: begin
        regWr = 1'b1;
        case (cnt[1:0])
          2'd0:    stb.wrSel = WS_DEC;
          2'd1:    stb.wrSel = WS_WIN;
          2'd2:    stb.wrSel = WS_PAGE;
          default: stb.wrSel = WS_EXT;
        endcase
        if (cnt == DEC_END) begin
          cntNext   = '0;
          stateNext = S_IRQRD;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      S_IRQRD: begin
        eeReq  = 1'b1;
        eeAddr = EE_AW'(IRQ_WORD);
        if (eeAck) begin
          stb.irqCapture = 1'b1;
          stateNext      = S_IRQWR;
        end
      end
      S_IRQWR: begin
        regWr     = 1'b1;
        stb.wrSel = WS_IRQ;
        stateNext = S_PASS;
      end
      S_PASS:  stateNext = S_IDLE;
      S_FAIL:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign done   = (state == S_PASS) || (state == S_FAIL);
  assign passed = passReg;

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  pass_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(passed) |-> done);

  // R8
  ee_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eeReq && !eeAck) |=> (eeReq && $stable(eeAddr)));

  // R2
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regRd));

endmodule

// File: rtl/adapter_probe.sv
module adapter_probe
  import probe_pkg::*;
#(
  parameter logic [15:0] BOARD_ID    = 16'h5A3C,
  parameter int          WAIT_CYCLES = 12000,
  parameter int          CFG_WORD    = 6,
  parameter int          IRQ_WORD    = 1,
  parameter int          IRQ_LSB     = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        regWr,
  output logic        regRd,
  output logic [7:0]  regAddr,
  output logic [7:0]  regWdata,
  input  logic [7:0]  regRdata,
  output logic        eeReq,
  output logic [5:0]  eeAddr,
  input  logic        eeAck,
  input  logic [15:0] eeData,
  output logic        done,
  output logic        passed,
  output logic        present,
  output logic        memValid,
  output logic [19:0] memBase,
  output logic [6:0]  memKb,
  output logic        pioMode,
  output logic [3:0]  irqNum,
  output logic [7:0]  decodeVal,
  output logic [7:0]  pageVal,
  output logic [7:0]  extVal
);

  strobe_t stb;
  logic    idMatch, memOk, pioSel, sumOk;

  probe_ctrl #(
    .WAIT_CYCLES(WAIT_CYCLES),
    .CFG_WORD   (CFG_WORD),
    .IRQ_WORD   (IRQ_WORD)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .eeAck  (eeAck),
    .idMatch(idMatch),
    .memOk  (memOk),
    .pioSel (pioSel),
    .sumOk  (sumOk),
    .stb    (stb),
    .regWr  (regWr),
    .regRd  (regRd),
    .eeReq  (eeReq),
    .eeAddr (eeAddr),
    .done   (done),
    .passed (passed)
  );

  probe_datapath #(
    .BOARD_ID(BOARD_ID),
    .IRQ_LSB (IRQ_LSB)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regRd    (regRd),
    .regRdata (regRdata),
    .eeData   (eeData),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .idMatch  (idMatch),
    .memOk    (memOk),
    .pioSel   (pioSel),
    .sumOk    (sumOk),
    .present  (present),
    .memValid (memValid),
    .memBase  (memBase),
    .memKb    (memKb),
    .pioMode  (pioMode),
    .irqNum   (irqNum),
    .decodeVal(decodeVal),
    .pageVal  (pageVal),
    .extVal   (extVal)
  );

  // R2
  reset_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == CTRL_REG && regWdata == ASIC_RST) |=>
      (regWr && regAddr == CTRL_REG && regWdata == 8'h00));

  // R11
  irq_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == IRQ_REG) |-> !regWdata[IRQ_EN_BIT]);

  // R4
  absent_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !present) |-> !passed);

endmodule

// File: tb/adapter_probe_tb.sv
module adapter_probe_tb;
  import probe_pkg::*;

  localparam logic [15:0] BID   = 16'h5A3C;
  localparam int          WAITC = 50;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        regWr, regRd;
  logic [7:0]  regAddr, regWdata, regRdata;
  logic        eeReq;
  logic [5:0]  eeAddr;
  logic        eeAck = 1'b0;
  logic [15:0] eeData = '0;
  logic        done, passed, present, memValid, pioMode;
  logic [19:0] memBase;
  logic [6:0]  memKb;
  logic [3:0]  irqNum;
  logic [7:0]  decodeVal, pageVal, extVal;

  always #10 clk = ~clk;

  adapter_probe #(.BOARD_ID(BID), .WAIT_CYCLES(WAITC)) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .eeReq(eeReq), .eeAddr(eeAddr), .eeAck(eeAck), .eeData(eeData),
    .done(done), .passed(passed), .present(present), .memValid(memValid),
    .memBase(memBase), .memKb(memKb), .pioMode(pioMode), .irqNum(irqNum),
    .decodeVal(decodeVal), .pageVal(pageVal), .extVal(extVal)
  );

  // Bus and EEPROM models
  logic [7:0]  idSeq [4];
  logic [7:0]  idIdx = '0;
  logic [15:0] eeMem [64];
  logic [7:0]  wrA [64];
  logic [7:0]  wrD [64];
  int          wrC [64];
  logic [5:0]  eeLog [256];
  int wrCnt = 0, eeCnt = 0, cyc = 0, rdCyc = 0;

  assign regRdata = (regRd && regAddr == ID_REG) ? idSeq[idIdx[1:0]] : 8'h00;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (regRd && regAddr == ID_REG) begin
      if (idIdx[1:0] == 2'd0) rdCyc <= cyc;
      idIdx <= idIdx + 8'd1;
    end
    if (regWr) begin
      wrA[wrCnt % 64] <= regAddr;
      wrD[wrCnt % 64] <= regWdata;
      wrC[wrCnt % 64] <= cyc;
      wrCnt <= wrCnt + 1;
    end
    eeAck  <= eeReq && !eeAck;
    eeData <= eeMem[eeAddr];
    if (eeReq && eeAck) begin
      eeLog[eeCnt % 256] <= eeAddr;
      eeCnt <= eeCnt + 1;
    end
  end

  int nChecks = 0, nErr = 0;
  int wrStart, eeStart;
  logic rPassed, rPresent, rMemValid, rPio;
  logic [19:0] rBase;
  logic [6:0]  rKb;
  logic [3:0]  rIrq;
  logic [7:0]  rDec, rPage, rExt;

  task automatic chkEq(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic fillEe(input logic [15:0] w6, input logic [15:0] cfg, input logic [15:0] skew);
    logic [15:0] s = '0;
    for (int i = 0; i < 64; i++) eeMem[i] = 16'(i * 16'h0107);
    eeMem[6] = w6;
    eeMem[1] = cfg;
    for (int i = 0; i < 63; i++) s = s + eeMem[i];
    eeMem[63] = BID - s + skew;
  endtask

  task automatic goodId();
    idSeq[0] = 8'hA2; idSeq[1] = 8'hCC; idSeq[2] = 8'h53; idSeq[3] = 8'h31;
  endtask

  task automatic runProbe();
    int n = 0;
    wrStart = wrCnt;
    eeStart = eeCnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chkEq("R12", "done seen", {31'd0, done}, 32'd1);
    rPassed = passed; rPresent = present; rMemValid = memValid; rPio = pioMode;
    rBase = memBase; rKb = memKb; rIrq = irqNum; rDec = decodeVal; rPage = pageVal; rExt = extVal;
    @(negedge clk);
    chkEq("R12", "done one cycle", {31'd0, done}, 32'd0);
    repeat (3) @(negedge clk);
    chkEq("R12", "passed held", {31'd0, passed}, {31'd0, rPassed});
  endtask

  task automatic chkWr(input int k, input string tag, input logic [7:0] a, input logic [7:0] d);
    chkEq(tag, $sformatf("write %0d addr", k), {24'd0, wrA[(wrStart + k) % 64]}, {24'd0, a});
    chkEq(tag, $sformatf("write %0d data", k), {24'd0, wrD[(wrStart + k) % 64]}, {24'd0, d});
  endtask

  task automatic chkPrologue();
    chkWr(0, "R2", CTRL_REG, ASIC_RST);
    chkWr(1, "R2", CTRL_REG, 8'h00);
    chkEq("R2", "wait gap", 32'(rdCyc - wrC[(wrStart + 1) % 64]), 32'(WAITC + 1));
  endtask

  // Passing probe with a given window byte and IRQ code
  task automatic passCase(input string tag, input logic [15:0] w6, input logic [2:0] code,
                          input logic [19:0] eBase, input logic [6:0] eKb, input logic ePio,
                          input logic [7:0] eDec, input logic [7:0] eWin, input logic [7:0] ePage,
                          input logic [7:0] eExt, input logic [3:0] eIrq);
    int irqPos;
    goodId();
    fillEe(w6, {code, 13'h0155}, 16'h0000);
    runProbe();
    chkEq("R12", {tag, " passed"}, {31'd0, rPassed}, 32'd1);
    chkEq("R3", {tag, " present"}, {31'd0, rPresent}, 32'd1);
    chkEq(tag, "memValid", {31'd0, rMemValid}, 32'd1);
    chkEq(tag, "base", {12'd0, rBase}, {12'd0, eBase});
    chkEq(tag, "size", {25'd0, rKb}, {25'd0, eKb});
    chkEq("R9", {tag, " pio"}, {31'd0, rPio}, {31'd0, ePio});
    chkEq("R11", {tag, " irq"}, {28'd0, rIrq}, {28'd0, eIrq});
    chkPrologue();
    chkWr(2, "R8", CTRL_REG, NET_RST);
    chkEq("R8", "ee count", 32'(eeCnt - eeStart), 32'd66);
    chkEq("R5", "first ee word", {26'd0, eeLog[eeStart % 256]}, 32'd6);
    for (int i = 0; i < 64; i++)
      if (eeLog[(eeStart + 1 + i) % 256] != 6'(i))
        chkEq("R8", "sum order", {26'd0, eeLog[(eeStart + 1 + i) % 256]}, 32'(i));
    if (!ePio) begin
      chkWr(3, "R10", DEC_REG, eDec);
      chkWr(4, "R10", WIN_REG, eWin);
      chkWr(5, "R10", PAGE_REG, ePage);
      chkWr(6, "R10", EXT_REG, eExt);
      chkEq("R10", "decode out", {24'd0, rDec, rPage, rExt}, {24'd0, eDec, ePage, eExt});
      irqPos = 7;
    end else begin
      irqPos = 3;
    end
    chkWr(irqPos, "R11", IRQ_REG, {5'd0, code});
    chkEq("R9", {tag, " write count"}, 32'(wrCnt - wrStart), 32'(irqPos + 1));
  endtask

  task automatic resetCheck();
    chkEq("R1", "done", {31'd0, done}, 32'd0);
    chkEq("R1", "passed", {31'd0, passed}, 32'd0);
    chkEq("R1", "present", {31'd0, present}, 32'd0);
    chkEq("R1", "memValid", {31'd0, memValid}, 32'd0);
    chkEq("R1", "strobes", {29'd0, regWr, regRd, eeReq}, 32'd0);
  endtask

  task automatic badIdCase();
    idSeq[0] = 8'hA2; idSeq[1] = 8'hC0; idSeq[2] = 8'h53; idSeq[3] = 8'h30;
    fillEe(16'h0070, 16'h2000, 16'h0000);
    runProbe();
    chkEq("R4", "passed", {31'd0, rPassed}, 32'd0);
    chkEq("R4", "present", {31'd0, rPresent}, 32'd0);
    chkEq("R4", "ee requests", 32'(eeCnt - eeStart), 32'd0);
    chkEq("R4", "write count", 32'(wrCnt - wrStart), 32'd2);
  endtask

  task automatic badWinCase();
    goodId();
    fillEe(16'h005C, 16'h2000, 16'h0000);
    runProbe();
    chkEq("R7", "passed", {31'd0, rPassed}, 32'd0);
    chkEq("R7", "present", {31'd0, rPresent}, 32'd1);
    chkEq("R7", "memValid", {31'd0, rMemValid}, 32'd0);
    chkEq("R7", "write count", 32'(wrCnt - wrStart), 32'd2);
    chkEq("R7", "ee requests", 32'(eeCnt - eeStart), 32'd1);
  endtask

  task automatic badSumCase();
    goodId();
    fillEe(16'h0070, 16'h2000, 16'h0001);
    runProbe();
    chkEq("R8", "passed", {31'd0, rPassed}, 32'd0);
    chkEq("R8", "memValid", {31'd0, rMemValid}, 32'd1);
    chkEq("R8", "irq", {28'd0, rIrq}, 32'd0);
    chkEq("R8", "write count", 32'(wrCnt - wrStart), 32'd3);
    chkEq("R8", "ee requests", 32'(eeCnt - eeStart), 32'd65);
  endtask

  task automatic irqMapCase();
    logic [3:0] expIrq [8];
    expIrq[0] = 4'd0; expIrq[1] = 4'd9;  expIrq[2] = 4'd3;  expIrq[3] = 4'd4;
    expIrq[4] = 4'd5; expIrq[5] = 4'd10; expIrq[6] = 4'd11; expIrq[7] = 4'd0;
    for (int c = 0; c < 8; c++) begin
      goodId();
      fillEe(16'hFF00, {3'(c), 13'h1ABC}, 16'h0000);
      runProbe();
      chkEq("R11", $sformatf("code %0d", c), {28'd0, rIrq}, {28'd0, expIrq[c]});
      chkEq("R6", "no-memory pass", {29'd0, rPassed, rMemValid, rPio}, 32'd7);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    goodId();
    fillEe(16'h0000, 16'h0000, 16'h0000);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    resetCheck();
    passCase("R5 64K", 16'hA53C, 3'd5, 20'hC8000, 7'd64, 1'b0, 8'h3C, 8'h18, 8'hC3, 8'hF0, 4'd10);
    passCase("R5 48K", 16'h0070, 3'd1, 20'hD0000, 7'd48, 1'b0, 8'h70, 8'h10, 8'h8F, 8'hF0, 4'd9);
    passCase("R5 32K", 16'hFFC0, 3'd6, 20'hD8000, 7'd32, 1'b0, 8'hC0, 8'h18, 8'h3F, 8'hF0, 4'd11);
    passCase("R5 48K@0", 16'h0007, 3'd3, 20'hC0000, 7'd48, 1'b0, 8'h07, 8'h10, 8'hF8, 8'hF0, 4'd4);
    passCase("R9 16K", 16'h0080, 3'd2, 20'hDC000, 7'd16, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 4'd3);
    passCase("R6 none", 16'h1200, 3'd7, 20'h00000, 7'd0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 4'd0);
    badIdCase();
    badWinCase();
    badSumCase();
    irqMapCase();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule